// File: doc/BRIEF.md
# NOR Flash Buffered-Program Sequencer

This block runs the buffered program operation of a parallel NOR flash over a simple write-only memory bus. A host hands over one request, made of a start word address and a word count. It then streams the data words through a valid/ready handshake. The block expands this into the complete device write sequence:
- two unlock writes at fixed offsets;
- the buffer-load command and the count word, both at the start address;
- one write per data word at rising addresses;
- a confirm command aimed at the last address that was loaded.

Each bus write is held in registers until the bus accepts it. Requests with an illegal word count are refused at once and produce no bus traffic. A one-cycle completion pulse marks the end of a good sequence. Polling the device for completion, bus timing and erase commands belong to other blocks.

Top module: `nor_bufprog_loader`

## Requirements
- R1: After a legal request is accepted, the first two bus writes are data 0x00AA at address 0x555, then data 0x0055 at address 0x2AA.
- R2: The third write carries the buffer-load command 0x0025 to the request's start address.
- R3: The fourth write goes to the start address and carries the word count minus one, zero-extended.
- R4: Data words are written in the order they arrive, the k-th word (k from 0) to start address plus k, for k up to count minus one.
- R5: The final write carries the confirm command 0x0029 to the address of the last data word (start plus count minus one).
- R6: A request whose count is 0 or larger than MAX_WORDS issues no bus write. It raises `error` for exactly the one cycle after it is accepted, and the block stays ready.
- R7: While the block is waiting for data and `data_valid` is low, `bus_wr_valid` is low and the next data address does not advance. `data_ready` is high only while a data word is still owed and the bus write slot is empty or being accepted.
- R8: A write that is presented but not accepted keeps its address and data unchanged on the next cycle.
- R9: `done` is high for exactly the one cycle after the bus accepts the confirm write.
- R10: `req_ready` is high only when no sequence is in progress. Requests presented during a sequence are ignored.
- R11: After reset, `req_ready` is 1 and `bus_wr_valid`, `done`, `error` and `data_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Start word address |
| req_count | input | CW | Number of words, CW = clog2(MAX_WORDS+1) |
| data_valid | input | 1 | Data word offered |
| data_ready | output | 1 | Data word taken this cycle when valid |
| data_word | input | DW | Data word to program |
| bus_wr_valid | output | 1 | Bus write presented |
| bus_wr_ready | input | 1 | Bus accepts the presented write |
| bus_wr_addr | output | AW | Bus write word address |
| bus_wr_data | output | DW | Bus write data |
| done | output | 1 | One-cycle pulse after the confirm write is accepted |
| error | output | 1 | One-cycle pulse after an illegal request |

## Verification
The bench builds the block with MAX_WORDS set to 8, and AW and DW both 16. With these values a full buffer, a single word, and counts one above the limit and far above it (9 and 15) all fit in the 4-bit count field within a few dozen cycles. Random bus backpressure and random data gaps are mixed with always-ready runs. This exercises write holding, data-phase bubbles, the case where the last data word and the confirm write follow each other back to back, and requests presented while a sequence is in progress.

// File: rtl/nor_bufprog_pkg.sv
package nor_bufprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLOCK_A,
    ST_UNLOCK_B,
    ST_LOAD,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM
  } seq_state_t;

  localparam logic [15:0] UNLOCK_A_ADDR   = 16'h0555;
  localparam logic [15:0] UNLOCK_A_DATA   = 16'h00AA;
  localparam logic [15:0] UNLOCK_B_ADDR   = 16'h02AA;
  localparam logic [15:0] UNLOCK_B_DATA   = 16'h0055;
  localparam logic [15:0] CMD_BUF_LOAD    = 16'h0025;
  localparam logic [15:0] CMD_BUF_CONFIRM = 16'h0029;

endpackage

// File: rtl/nor_count_check.sv
module nor_count_check #(
  parameter int MAX_WORDS = 32,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic [CW-1:0] count,
  output logic          legal
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WORDS);

  always_comb begin
    legal = (count != '0) && (count <= LIMIT);
  end
endmodule

// File: rtl/nor_word_tracker.sv
module nor_word_tracker #(
  parameter int AW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] count,
  input  logic          step,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] last_addr,
  output logic [CW-1:0] remaining,
  output logic          all_loaded
);
  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr <= '0;
      last_addr <= '0;
      remaining <= '0;
    end else if (load) begin
      next_addr <= start_addr;
      last_addr <= start_addr;
      remaining <= count;
    end else if (step) begin
      last_addr <= next_addr;
      next_addr <= next_addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  always_comb begin
    all_loaded = (remaining == '0);
  end
endmodule

// File: rtl/nor_bufprog_loader.sv
module nor_bufprog_loader
  import nor_bufprog_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          data_valid,
  output logic          data_ready,
  input  logic [DW-1:0] data_word,
  output logic          bus_wr_valid,
  input  logic          bus_wr_ready,
  output logic [AW-1:0] bus_wr_addr,
  output logic [DW-1:0] bus_wr_data,
  output logic          done,
  output logic          error
);
  seq_state_t    state_q;
  logic          req_legal;
  logic          req_fire;
  logic          slot_free;
  logic          accept;
  logic          take;
  logic          start_ok;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] last_addr;
  logic [CW-1:0] remaining;
  logic          all_loaded;

  nor_count_check #(.MAX_WORDS(MAX_WORDS), .CW(CW)) u_count_check (
    .count (req_count),
    .legal (req_legal)
  );

  nor_word_tracker #(.AW(AW), .CW(CW)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .load       (start_ok),
    .start_addr (req_addr),
    .count      (req_count),
    .step       (take),
    .next_addr  (next_addr),
    .last_addr  (last_addr),
    .remaining  (remaining),
    .all_loaded (all_loaded)
  );

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    req_fire   = req_valid && req_ready;
    start_ok   = req_fire && req_legal;
    accept     = bus_wr_valid && bus_wr_ready;
    slot_free  = !bus_wr_valid || bus_wr_ready;
    data_ready = (state_q == ST_DATA) && slot_free && !all_loaded;
    take       = data_ready && data_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      bus_wr_valid <= 1'b0;
      bus_wr_addr  <= '0;
      bus_wr_data  <= '0;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            bus_wr_valid <= 1'b1;
            bus_wr_addr  <= AW'(UNLOCK_A_ADDR);
            bus_wr_data  <= DW'(UNLOCK_A_DATA);
            state_q      <= ST_UNLOCK_A;
          end else if (req_fire) begin
            error <= 1'b1;
          end
        end
        ST_UNLOCK_A: begin
          if (accept) begin
            bus_wr_addr <= AW'(UNLOCK_B_ADDR);
            bus_wr_data <= DW'(UNLOCK_B_DATA);
            state_q     <= ST_UNLOCK_B;
          end
        end
        ST_UNLOCK_B: begin
          if (accept) begin
            bus_wr_addr <= next_addr;
            bus_wr_data <= DW'(CMD_BUF_LOAD);
            state_q     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            bus_wr_data <= DW'(remaining - 1'b1);
            state_q     <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (accept) begin
            bus_wr_valid <= 1'b0;
            state_q      <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (slot_free) begin
            if (take) begin
              bus_wr_valid <= 1'b1;
              bus_wr_addr  <= next_addr;
              bus_wr_data  <= data_word;
            end else if (all_loaded) begin
              bus_wr_valid <= 1'b1;
              bus_wr_addr  <= last_addr;
              bus_wr_data  <= DW'(CMD_BUF_CONFIRM);
              state_q      <= ST_CONFIRM;
            end else begin
              bus_wr_valid <= 1'b0;
            end
          end
        end
        ST_CONFIRM: begin
          if (accept) begin
            bus_wr_valid <= 1'b0;
            done         <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_bufprog_checker.sv
module nor_bufprog_checker
  import nor_bufprog_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          data_valid,
  input logic          data_ready,
  input logic          bus_wr_valid,
  input logic          bus_wr_ready,
  input logic [AW-1:0] bus_wr_addr,
  input logic [DW-1:0] bus_wr_data,
  input logic          done,
  input logic          error
);
  assert_first_unlock_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> (bus_wr_valid && bus_wr_addr == AW'(UNLOCK_A_ADDR)
                          && bus_wr_data == DW'(UNLOCK_A_DATA)));

  assert_take_presents_R4: assert property (@(posedge clk) disable iff (rst)
    (data_ready && data_valid) |=> bus_wr_valid);

  assert_error_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    error |-> (!bus_wr_valid && req_ready && $past(req_valid && req_ready)));

  assert_data_slot_R7: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (!bus_wr_valid || bus_wr_ready));

  assert_hold_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_valid && !bus_wr_ready) |=>
      (bus_wr_valid && $stable(bus_wr_addr) && $stable(bus_wr_data)));

  assert_done_after_confirm_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_wr_valid && bus_wr_ready && bus_wr_data == DW'(CMD_BUF_CONFIRM)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_no_bus_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_wr_valid);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, error}));
endmodule

bind nor_bufprog_loader nor_bufprog_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .data_valid   (data_valid),
  .data_ready   (data_ready),
  .bus_wr_valid (bus_wr_valid),
  .bus_wr_ready (bus_wr_ready),
  .bus_wr_addr  (bus_wr_addr),
  .bus_wr_data  (bus_wr_data),
  .done         (done),
  .error        (error)
);

// File: tb/sim_nor_bufprog_loader.sv
module sim_nor_bufprog_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int MAXW = 8;
  localparam int CW   = $clog2(MAXW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic          data_valid = 1'b0;
  logic          data_ready;
  logic [DW-1:0] data_word = '0;
  logic          bus_wr_valid;
  logic          bus_wr_ready = 1'b0;
  logic [AW-1:0] bus_wr_addr;
  logic [DW-1:0] bus_wr_data;
  logic          done;
  logic          error;

  nor_bufprog_loader #(.AW(AW), .DW(DW), .MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count),
    .data_valid(data_valid), .data_ready(data_ready), .data_word(data_word),
    .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready),
    .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // stimulus modes
  bit rand_ready = 0;
  bit rand_data  = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] src[$];

  // reference model state
  int          m_phase = 0;
  int          m_left = 0;
  int          m_next = 0;
  int          m_last = 0;
  bit          e_valid = 0;
  int          e_addr = 0;
  int          e_data = 0;
  bit          e_done = 0;
  bit          e_err = 0;
  string       e_tag = "R11";
  int          fq_addr[$];
  int          fq_data[$];
  string       fq_tag[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic present_next();
    e_valid = 1;
    e_addr  = fq_addr.pop_front();
    e_data  = fq_data.pop_front();
    e_tag   = fq_tag.pop_front();
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit free;
    if (rst) begin
      m_phase = 0; e_valid = 0; e_done = 0; e_err = 0; m_left = 0;
      fq_addr.delete(); fq_data.delete(); fq_tag.delete();
    end else begin
      e_done = 0;
      e_err  = 0;
      case (m_phase)
        0: if (req_valid) begin
          if (req_count == 0 || int'(req_count) > MAXW) e_err = 1;
          else begin
            fq_addr.push_back('h555);  fq_data.push_back('h00AA); fq_tag.push_back("R1");
            fq_addr.push_back('h2AA);  fq_data.push_back('h0055); fq_tag.push_back("R1");
            fq_addr.push_back(int'(req_addr)); fq_data.push_back('h0025); fq_tag.push_back("R2");
            fq_addr.push_back(int'(req_addr)); fq_data.push_back(int'(req_count) - 1); fq_tag.push_back("R3");
            m_next = int'(req_addr);
            m_left = int'(req_count);
            present_next();
            m_phase = 1;
          end
        end
        1: if (bus_wr_ready) begin
          if (fq_addr.size() > 0) present_next();
          else begin e_valid = 0; e_tag = "R7"; m_phase = 2; end
        end
        2: begin
          free = !e_valid || bus_wr_ready;
          if (free) begin
            if (m_left > 0) begin
              if (data_valid) begin
                e_valid = 1; e_addr = m_next; e_data = int'(src.pop_front()); e_tag = "R4";
                m_last = m_next; m_next = (m_next + 1) % (1 << AW); m_left--;
              end else begin
                e_valid = 0; e_tag = "R7";
              end
            end else begin
              e_valid = 1; e_addr = m_last; e_data = 'h0029; e_tag = "R5";
              m_phase = 3;
            end
          end
        end
        default: if (bus_wr_ready) begin
          e_valid = 0; e_done = 1; e_tag = "R10"; m_phase = 0;
        end
      endcase
    end
  end

  // drive away from the rising edge, then compare
  bit          p_hold = 0;
  int          p_addr = 0;
  int          p_data = 0;
  always @(negedge clk) begin
    bit exp_dr;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_wr_ready = rand_ready ? lfsr[3] : 1'b1;
    data_valid   = (src.size() > 0) && (rand_data ? lfsr[7] : 1'b1);
    data_word    = (src.size() > 0) ? src[0] : '0;
    #1;
    if (!rst && !finished) begin
      exp_dr = (m_phase == 2) && (!e_valid || bus_wr_ready) && (m_left > 0);
      check(bus_wr_valid == e_valid, e_tag, "bus_wr_valid", int'(bus_wr_valid), int'(e_valid));
      if (e_valid && bus_wr_valid) begin
        check(int'(bus_wr_addr) == e_addr, e_tag, "bus_wr_addr", int'(bus_wr_addr), e_addr);
        check(int'(bus_wr_data) == e_data, e_tag, "bus_wr_data", int'(bus_wr_data), e_data);
      end
      if (p_hold) begin
        check(int'(bus_wr_addr) == p_addr && int'(bus_wr_data) == p_data, "R8",
              "held write changed", int'(bus_wr_addr), p_addr);
      end
      check(done == e_done, "R9", "done", int'(done), int'(e_done));
      check(error == e_err, "R6", "error", int'(error), int'(e_err));
      check(req_ready == (m_phase == 0), "R10", "req_ready", int'(req_ready), int'(m_phase == 0));
      check(data_ready == exp_dr, "R7", "data_ready", int'(data_ready), int'(exp_dr));
      p_hold = bus_wr_valid && !bus_wr_ready;
      p_addr = int'(bus_wr_addr);
      p_data = int'(bus_wr_data);
    end
  end

  task automatic run_op(int addr, int count, bit rr, bit rd, bit poke_busy);
    rand_ready = rr;
    rand_data  = rd;
    if (count >= 1 && count <= MAXW)
      for (int i = 0; i < count; i++) src.push_back(DW'(16'h3C00 + addr + i * 7));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(addr);
    req_count = CW'(count);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      // R10: requests during a sequence must be ignored
      req_valid = 1'b1; req_count = '0; req_addr = 16'h7777;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (m_phase != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    src.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R11: state right after reset
    check(req_ready == 1'b1 && bus_wr_valid == 1'b0 && done == 1'b0 && error == 1'b0
          && data_ready == 1'b0, "R11", "reset outputs",
          int'({req_ready, bus_wr_valid, done, error, data_ready}), 'b10000);
    run_op('h1000, 1, 0, 0, 0);       // single word
    run_op('h2040, MAXW, 1, 0, 0);    // full buffer, bus backpressure
    run_op('h0300, 5, 1, 1, 0);       // gaps on both sides
    run_op('h0500, 0, 0, 0, 0);       // R6 zero count
    run_op('h0500, MAXW + 1, 0, 0, 0);// R6 one above limit
    run_op('h0600, 15, 1, 0, 0);      // R6 far above limit
    run_op('h0777, 3, 0, 0, 1);       // R10 requests while busy
    run_op('hFFFE, 4, 0, 1, 0);       // R4 data gaps, address increments
    run_op('h0123, 6, 1, 1, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule